// File: doc/BRIEF.md
# Diagnosable Local-Bus Cycle Sequencer

This block runs local-bus cycles on behalf of the per-port DMA logic of a multi-port I/O board, and it is built so that maintenance software can take it apart step by step. A cycle starts only after a check state. In that state the board-enable flag decides whether the machine goes on to request the bus or falls back to idle. Once the bus-go request has gone out, the sequencer waits for a completion handshake from the bus or a halt from the DMA engine. A watchdog counter abandons the wait if neither arrives within a parameterised number of clocks.

A small register interface holds the diagnostic controls, the port pointer and the board-enable flag, and returns a status word. The diagnostic controls are single-step, internal loopback of the handshake, and freeze. Single-step makes the machine advance one state per step strobe. Loopback lets a cycle complete with no responder on the bus. Freeze holds the machine where it stands and tells the port controllers to halt. An init strobe returns the whole block to its cleared state.

Top module: `lbus_seq`

## Requirements
- R1: A one-cycle init_i pulse, or reset, returns the state to 0 and clears the board-enable flag, the port pointer, the diagnostic control bits and both the timeout and error flags.
- R2: While board enable (register address 8, bit 0) is 0, the state that follows state 4 is state 0, so the machine only alternates between states 0 and 4.
- R3: Writing 1 to bit 0 of address 8 enables the board. From then on the state that follows state 4 is state 1, and state 1 is followed by state 2.
- R4: With single-step (address 0, bit 0) set, the state changes by exactly one transition per step_i pulse and holds while step_i is low. The only exception is the watchdog expiry in state 2.
- R5: With single-step clear, the machine leaves state 0 only in a cycle where start_i is high, and then advances one state per clock.
- R6: bus_go_o is high only in state 1, and only when the 4-bit port pointer (address 1, bits 3:0) is 0 to 7. With a pointer of 8 to 15, bus_go_o stays low and the error flag is set one clock after state 1 is entered.
- R7: In state 2, bus_end_i or dma_halt_i high on an advancing clock moves the machine to state 3. State 3 is followed by state 0.
- R8: If no handshake completes state 2, the machine spends exactly TO_CYCLES clocks (64 by default) in state 2, then goes to state 0 and sets the timeout flag. Both flags clear when the machine next leaves state 0.
- R9: With loopback (address 0, bit 1) set, state 2 completes on its first advancing clock without any external handshake.
- R10: With freeze (address 0, bit 2) set, freeze_halt_o is high, the state holds whatever step_i does, and the watchdog does not count.
- R11: Reading address 9 returns the state in bits 2:0, the timeout flag in bit 3 and the error flag in bit 4, with zeros above. state_o, timeout_o and error_o carry the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous board-clear strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| step_i | input | 1 | Single-step strobe |
| start_i | input | 1 | Cycle request from DMA logic (free-run mode) |
| bus_end_i | input | 1 | Bus cycle-end handshake |
| dma_halt_i | input | 1 | Halt from DMA engine, ends the wait |
| bus_go_o | output | 1 | Bus request |
| port_ptr_o | output | 4 | Current port pointer |
| freeze_halt_o | output | 1 | Halt to port controllers while frozen |
| state_o | output | 3 | Sequencer state number |
| timeout_o | output | 1 | Watchdog expired on last cycle |
| error_o | output | 1 | Illegal pointer seen on last cycle |

## Verification
The bench exercises the board-enable decision at state 4, where a wrong design would run the disabled board into state 1 or trap an enabled board in the 0/4 loop. It probes the pointer boundary with values 3, 5 and 9, which catches a design that asserts bus-go for an illegal port or forgets the error flag. It counts the clocks spent in state 2, so an off-by-one watchdog that exits after 63 or 65 clocks is exposed. It also holds the machine frozen in state 2 for 100 clocks, which catches a watchdog that keeps counting under freeze. Init is applied in the middle of an errored cycle, and the single-step and loopback paths are walked one state at a time, so a step that skips or repeats a state shows up at once.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GO   = 3'd1,
    ST_WAIT = 3'd2,
    ST_DONE = 3'd3,
    ST_CHK  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic freeze;
    logic loop_en;
    logic sstep;
  } diag_ctrl_t;

  localparam int unsigned DIAG_BITS = $bits(diag_ctrl_t);

  localparam logic [3:0] ADDR_DIAG = 4'd0;
  localparam logic [3:0] ADDR_PTR  = 4'd1;
  localparam logic [3:0] ADDR_BEN  = 4'd8;
  localparam logic [3:0] ADDR_STAT = 4'd9;

endpackage

// File: rtl/lbus_seq_regs.sv
module lbus_seq_regs
  import lbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o,
  output diag_ctrl_t        diag_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              board_en_o
);

  localparam logic [ADDR_W-1:0] A_DIAG = ADDR_W'(ADDR_DIAG);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(ADDR_PTR);
  localparam logic [ADDR_W-1:0] A_BEN  = ADDR_W'(ADDR_BEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  diag_ctrl_t       diag_q;
  logic [PTR_W-1:0] ptr_q;
  logic             ben_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_q <= '0;
      ptr_q  <= '0;
      ben_q  <= 1'b0;
    end else if (init_i) begin
      diag_q <= '0;
      ptr_q  <= '0;
      ben_q  <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_DIAG:  diag_q <= diag_ctrl_t'(wdata_i[DIAG_BITS-1:0]);
        A_PTR:   ptr_q  <= wdata_i[PTR_W-1:0];
        A_BEN:   ben_q  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DIAG:  rdata_o[DIAG_BITS-1:0] = diag_q;
      A_PTR:   rdata_o[PTR_W-1:0]     = ptr_q;
      A_BEN:   rdata_o[0]             = ben_q;
      A_STAT:  rdata_o                = status_i;
      default: rdata_o = '0;
    endcase
  end

  assign diag_o     = diag_q;
  assign ptr_o      = ptr_q;
  assign board_en_o = ben_q;

  // R1
  init_clears_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!ben_q && ptr_q == '0 && diag_q == '0));

endmodule

// File: rtl/lbus_seq_wdog.sv
module lbus_seq_wdog #(
  parameter int unsigned TO_CYCLES = 64,
  localparam int unsigned CNT_W    = $clog2(TO_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_wait_i,
  input  logic run_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = in_wait_i && run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!in_wait_i)            cnt_q <= '0;
    else if (run_i && !expire_o)    cnt_q <= cnt_q + 1'b1;
  end

  // R8
  wdog_idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_wait_i |=> (cnt_q == '0));

  // R10
  wdog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait_i && !run_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lbus_seq_fsm.sv
module lbus_seq_fsm
  import lbus_seq_pkg::*;
#(
  parameter int unsigned PTR_W     = 4,
  parameter int unsigned NUM_PORTS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             start_i,
  input  logic             bus_end_i,
  input  logic             dma_halt_i,
  input  diag_ctrl_t       diag_i,
  input  logic             board_en_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             expire_i,
  output seq_state_e       state_o,
  output logic             bus_go_o,
  output logic             in_wait_o,
  output logic             run_o,
  output logic             timeout_o,
  output logic             error_o
);

  seq_state_e state_q, state_d;
  logic       adv, hs, ptr_ok, leave_idle;
  logic       timeout_q, error_q;

  assign ptr_ok = (32'(ptr_i) < NUM_PORTS);
  assign adv    = !diag_i.freeze && (diag_i.sstep ? step_i : 1'b1);
  assign hs     = bus_end_i || dma_halt_i || diag_i.loop_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (adv && (diag_i.sstep || start_i)) state_d = ST_CHK;
      ST_CHK:  if (adv) state_d = board_en_i ? ST_GO : ST_IDLE;
      ST_GO:   if (adv) state_d = ST_WAIT;
      ST_WAIT: begin
        if (adv && hs)     state_d = ST_DONE;
        else if (expire_i) state_d = ST_IDLE;
      end
      ST_DONE: if (adv) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign leave_idle = (state_q == ST_IDLE) && (state_d != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
      error_q   <= 1'b0;
    end else if (init_i) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (leave_idle) begin
        timeout_q <= 1'b0;
        error_q   <= 1'b0;
      end else begin
        if (state_q == ST_WAIT && state_d == ST_IDLE) timeout_q <= 1'b1;
        if (state_q == ST_GO && !ptr_ok)              error_q   <= 1'b1;
      end
    end
  end

  assign state_o   = state_q;
  assign bus_go_o  = (state_q == ST_GO) && ptr_ok;
  assign in_wait_o = (state_q == ST_WAIT);
  assign run_o     = !diag_i.freeze;
  assign timeout_o = timeout_q;
  assign error_o   = error_q;

  // R11
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_IDLE, ST_GO, ST_WAIT, ST_DONE, ST_CHK});

  // R2
  disabled_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHK && !board_en_i && !init_i) |=> (state_q inside {ST_CHK, ST_IDLE}));

  // R10
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_i.freeze && !init_i) |=> $stable(state_q));

  // R4
  step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_i.sstep && !step_i && state_q != ST_WAIT && !init_i) |=> $stable(state_q));

  // R8
  timeout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_q) |-> (state_q == ST_IDLE));

  // R1
  init_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (state_q == ST_IDLE && !timeout_q && !error_q));

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PTR_W     = 4,
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned TO_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              step_i,
  input  logic              start_i,
  input  logic              bus_end_i,
  input  logic              dma_halt_i,
  output logic              bus_go_o,
  output logic [PTR_W-1:0]  port_ptr_o,
  output logic              freeze_halt_o,
  output logic [2:0]        state_o,
  output logic              timeout_o,
  output logic              error_o
);

  diag_ctrl_t       diag;
  logic             board_en, expire, in_wait, run;
  seq_state_e       state;
  logic [DATA_W-1:0] status;

  always_comb begin
    status      = '0;
    status[2:0] = state;
    status[3]   = timeout_o;
    status[4]   = error_o;
  end

  lbus_seq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .status_i   (status),
    .rdata_o    (reg_rdata_o),
    .diag_o     (diag),
    .ptr_o      (port_ptr_o),
    .board_en_o (board_en)
  );

  lbus_seq_fsm #(
    .PTR_W     (PTR_W),
    .NUM_PORTS (NUM_PORTS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_i),
    .step_i     (step_i),
    .start_i    (start_i),
    .bus_end_i  (bus_end_i),
    .dma_halt_i (dma_halt_i),
    .diag_i     (diag),
    .board_en_i (board_en),
    .ptr_i      (port_ptr_o),
    .expire_i   (expire),
    .state_o    (state),
    .bus_go_o   (bus_go_o),
    .in_wait_o  (in_wait),
    .run_o      (run),
    .timeout_o  (timeout_o),
    .error_o    (error_o)
  );

  lbus_seq_wdog #(
    .TO_CYCLES (TO_CYCLES)
  ) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_wait_i (in_wait),
    .run_i     (run),
    .expire_o  (expire)
  );

  assign state_o       = state;
  assign freeze_halt_o = diag.freeze;

  // R6
  go_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_go_o |-> (state_o == 3'd1 && !error_o));

  // R8
  expire_in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> (state_o == 3'd2));

endmodule

// File: tb/lbus_seq_bench.sv
module lbus_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0, we = 1'b0, step = 1'b0, start = 1'b0;
  logic       bus_end = 1'b0, dma_halt = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       bus_go, freeze_halt, timeout, error;
  logic [3:0] ptr;
  logic [2:0] state;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lbus_seq u_lbus_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .init_i        (init),
    .reg_we_i      (we),
    .reg_addr_i    (addr),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .step_i        (step),
    .start_i       (start),
    .bus_end_i     (bus_end),
    .dma_halt_i    (dma_halt),
    .bus_go_o      (bus_go),
    .port_ptr_o    (ptr),
    .freeze_halt_o (freeze_halt),
    .state_o       (state),
    .timeout_o     (timeout),
    .error_o       (error)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_step();
    step = 1'b1;
    tick();
    step = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic do_init();
    init = 1'b1;
    tick();
    init = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 reset state", state, 0);
    check("R1 reset bus_go", bus_go, 0);
    check("R1 reset freeze_halt", freeze_halt, 0);
    rd(4'd8, v);  check("R1 reset board enable", v, 0);
    rd(4'd9, v);  check("R11 reset status", v, 0);
    rd(4'd0, v);  check("R1 reset diag", v, 0);
  endtask

  task automatic t_disabled_loop();
    do_init();
    wr(4'd0, 8'h01);
    pulse_step(); check("R2 step 0->4", state, 4);
    pulse_step(); check("R2 disabled 4->0", state, 0);
    pulse_step(); check("R2 step 0->4 again", state, 4);
    repeat (5) tick();
    check("R4 no step holds", state, 4);
    pulse_step(); check("R2 disabled 4->0 again", state, 0);
  endtask

  task automatic t_enabled_step();
    logic [7:0] v;
    do_init();
    wr(4'd0, 8'h01);
    wr(4'd8, 8'h01);
    rd(4'd8, v); check("R3 enable readback", v, 1);
    pulse_step(); check("R4 step to 4", state, 4);
    pulse_step(); check("R3 enabled 4->1", state, 1);
    check("R6 bus_go in state 1 ptr 0", bus_go, 1);
    pulse_step(); check("R3 1->2", state, 2);
    check("R6 bus_go low in state 2", bus_go, 0);
    tick(); tick(); check("R4 wait holds w/o step", state, 2);
    bus_end = 1'b1;
    pulse_step(); check("R7 bus_end 2->3", state, 3);
    bus_end = 1'b0;
    pulse_step(); check("R7 3->0", state, 0);
    check("R8 no timeout after handshake", timeout, 0);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    int n;
    do_init();
    wr(4'd8, 8'h01);
    wr(4'd1, 8'h03);
    tick(); check("R5 idle without start", state, 0);
    pulse_start(); check("R5 start 0->4", state, 4);
    tick(); check("R5 free-run 4->1", state, 1);
    check("R6 bus_go ptr 3", bus_go, 1);
    tick(); check("R5 free-run 1->2", state, 2);
    n = 1;
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (state != 2) break;
      n++;
    end
    check("R8 cycles in state 2", n, 64);
    check("R8 timeout back to 0", state, 0);
    check("R8 timeout flag", timeout, 1);
    rd(4'd9, v); check("R11 status after timeout", v, 8'h08);
    pulse_start(); check("R8 restart state 4", state, 4);
    check("R8 timeout cleared on restart", timeout, 0);
  endtask

  task automatic t_illegal_ptr();
    logic [7:0] v;
    do_init();
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h09);
    wr(4'd8, 8'h01);
    pulse_step(); pulse_step();
    check("R6 illegal ptr state 1", state, 1);
    check("R6 illegal ptr bus_go low", bus_go, 0);
    tick();
    check("R6 error flag set", error, 1);
    rd(4'd9, v); check("R11 status err+state1", v, 8'h11);
    pulse_step(); check("R6 to state 2", state, 2);
    for (int i = 0; i < 200; i++) begin
      if (state != 2) break;
      tick();
    end
    check("R8 single-step timeout to 0", state, 0);
    rd(4'd9, v); check("R11 status err+timeout", v, 8'h18);
    do_init();
    rd(4'd9, v); check("R1 init clears status", v, 0);
    rd(4'd8, v); check("R1 init clears enable", v, 0);
    rd(4'd1, v); check("R1 init clears ptr", v, 0);
  endtask

  task automatic t_loop_and_halt();
    do_init();
    wr(4'd0, 8'h02);
    wr(4'd8, 8'h01);
    wr(4'd1, 8'h05);
    pulse_start(); check("R9 loop state 4", state, 4);
    tick(); check("R9 loop state 1", state, 1);
    check("R6 bus_go ptr 5", bus_go, 1);
    tick(); check("R9 loop state 2", state, 2);
    tick(); check("R9 loopback completes 2->3", state, 3);
    tick(); check("R7 loop 3->0", state, 0);
    check("R9 no timeout", timeout, 0);
    do_init();
    wr(4'd8, 8'h01);
    pulse_start(); tick(); tick();
    check("R7 reach state 2", state, 2);
    tick(); check("R7 wait holds w/o handshake", state, 2);
    dma_halt = 1'b1;
    tick(); check("R7 dma_halt 2->3", state, 3);
    dma_halt = 1'b0;
    tick(); check("R7 3->0 after halt", state, 0);
  endtask

  task automatic t_freeze();
    do_init();
    wr(4'd0, 8'h01);
    wr(4'd8, 8'h01);
    pulse_step(); pulse_step();
    wr(4'd0, 8'h05);
    check("R10 freeze_halt high", freeze_halt, 1);
    pulse_step(); check("R10 frozen in state 1", state, 1);
    wr(4'd0, 8'h01);
    check("R10 freeze_halt low", freeze_halt, 0);
    pulse_step(); check("R10 to state 2", state, 2);
    wr(4'd0, 8'h05);
    repeat (100) tick();
    check("R10 frozen in state 2", state, 2);
    check("R10 no timeout while frozen", timeout, 0);
    pulse_step(); check("R10 step ignored frozen", state, 2);
    wr(4'd0, 8'h03);
    pulse_step(); check("R9 loopback step 2->3", state, 3);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_disabled_loop();
    t_enabled_step();
    t_timeout();
    t_illegal_ptr();
    t_loop_and_halt();
    t_freeze();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule